// File: doc/BRIEF.md
# Tagged Per-Call Memory Controller

This block serves load and store sub-operations between staging registers and a word-addressed memory. The memory is split into one region per call pointer, and each region has its own address space. Every cell holds a data word and a three-bit type tag. A store writes the word together with the instruction's tag. A load returns the stored word and tag, and raises a tag-error flag when the stored tag disagrees with the tag the instruction expects.

A cell that has never been written since its region was opened reads as zero with the uninitialized tag. The uninitialized tag is accepted by an instruction of any tag. Opening a new call clears every cell of that call's region in a single cycle, through a per-region presence map.

One request is accepted per cycle. Its response appears one cycle later, stamped with the cycle number at which the request was presented, so that accesses can be correlated with an execution trace. The model uses a reduced address width and a bounded number of call regions, both set by parameters.

Top module: `tagged_mem_ctl`

## Requirements
- R1: While reset is asserted, and in the cycles after release until the first request, `rsp_valid` is 0. The cycle counter is 0 in the first cycle after reset is released.
- R2: A request accepted at a clock edge produces `rsp_valid`=1 in the following cycle. `rsp_valid` is 0 in any cycle that follows a cycle with no request.
- R3: An access to a cell not written since reset, or since its region was last cleared, reports data 0 and tag 0 (uninitialized), with no tag error for any instruction tag.
- R4: A load reports exactly the data and tag of the most recent store to the same call pointer and address. Stores to one call pointer never change what another call pointer reads at the same address.
- R5: Tag codes are 0 uninitialized, 1 u8, 2 u16, 3 u32, 4 u64, 5 u128, 6 field. `rsp_tag_err` is 1 exactly when the reported cell tag is nonzero and differs from the request's `req_tag`.
- R6: A store writes `req_wdata` with `req_tag` as the new cell tag, whatever the cell held before. The response to the store reports the contents the cell held before the store, and applies the tag-error rule of R5 to those contents.
- R7: A pulse on `call_start` with pointer `call_start_ptr` makes every cell of that region read as uninitialized (R3). Other regions keep their contents.
- R8: When a clear and a request fall in the same cycle, the request's response reports the pre-clear contents. A store in that cycle into the region being cleared is kept after the clear.
- R9: `rsp_cyc` equals the number of clock edges between reset release and the edge that accepted the request. The count wraps modulo 2^CYC_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_call | input | CALL_W | Call pointer selecting the region |
| req_addr | input | ADDR_W | Word address within the region |
| req_wdata | input | DATA_W | Store data |
| req_tag | input | 3 | Instruction tag |
| call_start | input | 1 | Clear the region named by call_start_ptr |
| call_start_ptr | input | CALL_W | Region to clear |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | DATA_W | Cell data before the access |
| rsp_tag | output | 3 | Cell tag before the access |
| rsp_tag_err | output | 1 | Cell tag conflicts with instruction tag |
| rsp_cyc | output | CYC_W | Cycle number of the request |

## Verification
The hardest case to reach from the ports is a clear that coincides with a request, because the outcome depends on ordering inside one edge. The read must see the pre-clear contents, while a store into the region being cleared must survive. The bench first fills every cell of every region with a known pattern. It then issues clears paired with a load of a populated cell, and paired with a store into the cleared region. A full sweep of all regions afterwards shows what survived. Tag errors are swept by loading each filled cell under several instruction tags, so every pairing of stored tag and instruction tag, including the uninitialized tag, is visited.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  localparam int TAG_W = 3;
  localparam logic [TAG_W-1:0] TAG_NONE = 3'd0;

  // A conflict needs a defined cell tag that disagrees with the instruction.
  function automatic logic tag_clash(input logic [TAG_W-1:0] cell_tag,
                                     input logic [TAG_W-1:0] instr_tag);
    return (cell_tag != TAG_NONE) && (cell_tag != instr_tag);
  endfunction
endpackage

// File: rtl/mc_cycle_ctr.sv
module mc_cycle_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + W'(1);
  end
endmodule

// File: rtl/mc_valid_map.sv
module mc_valid_map #(
  parameter int NUM_CALLS = 4,
  parameter int ADDR_W    = 4,
  parameter int CALL_W    = 2,
  localparam int DEPTH    = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [CALL_W-1:0] clr_call,
  input  logic              set,
  input  logic [CALL_W-1:0] acc_call,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              hit_q
);
  logic [NUM_CALLS-1:0][DEPTH-1:0] present;

  // Clear first, then set: a store in the clearing cycle survives (R8).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      present <= '0;
      hit_q   <= 1'b0;
    end else begin
      hit_q <= present[acc_call][acc_addr];
      if (clr) present[clr_call] <= '0;
      if (set) present[acc_call][acc_addr] <= 1'b1;
    end
  end
endmodule

// File: rtl/mc_cell_store.sv
module mc_cell_store #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  localparam int CELLS = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [TAG_W-1:0]  wtag,
  output logic [DATA_W-1:0] rdata_q,
  output logic [TAG_W-1:0]  rtag_q
);
  logic [DATA_W-1:0] data_mem [CELLS];
  logic [TAG_W-1:0]  tag_mem  [CELLS];

  always_ff @(posedge clk) begin
    if (we) begin
      data_mem[idx] <= wdata;
      tag_mem[idx]  <= wtag;
    end
  end

  // The read register samples the pre-write contents of the addressed cell.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rtag_q  <= '0;
    end else begin
      rdata_q <= data_mem[idx];
      rtag_q  <= tag_mem[idx];
    end
  end
endmodule

// File: rtl/tagged_mem_ctl.sv
module tagged_mem_ctl
  import tmc_pkg::*;
#(
  parameter int NUM_CALLS = 4,
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 16,
  parameter int CYC_W     = 16,
  parameter int CALL_W    = (NUM_CALLS > 1) ? $clog2(NUM_CALLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CALL_W-1:0] req_call,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [2:0]        req_tag,
  input  logic              call_start,
  input  logic [CALL_W-1:0] call_start_ptr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [2:0]        rsp_tag,
  output logic              rsp_tag_err,
  output logic [CYC_W-1:0]  rsp_cyc
);
  localparam int IDX_W = CALL_W + ADDR_W;

  // Named internal events
  logic              wr_fire;
  logic              clr_fire;
  logic              cell_hit;
  logic [IDX_W-1:0]  cell_idx;
  logic [CYC_W-1:0]  cyc_cnt;
  logic [DATA_W-1:0] raw_data;
  logic [TAG_W-1:0]  raw_tag;
  logic [TAG_W-1:0]  instr_tag_q;

  assign wr_fire  = req_valid && req_write;
  assign clr_fire = call_start;
  assign cell_idx = {req_call, req_addr};

  mc_cycle_ctr #(.W(CYC_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .count(cyc_cnt)
  );

  mc_valid_map #(.NUM_CALLS(NUM_CALLS), .ADDR_W(ADDR_W), .CALL_W(CALL_W)) u_map (
    .clk(clk), .rst_n(rst_n),
    .clr(clr_fire), .clr_call(call_start_ptr),
    .set(wr_fire), .acc_call(req_call), .acc_addr(req_addr),
    .hit_q(cell_hit)
  );

  mc_cell_store #(.IDX_W(IDX_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_fire), .idx(cell_idx),
    .wdata(req_wdata), .wtag(req_tag),
    .rdata_q(raw_data), .rtag_q(raw_tag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      instr_tag_q <= TAG_NONE;
      rsp_cyc     <= '0;
    end else begin
      rsp_valid   <= req_valid;
      instr_tag_q <= req_tag;
      rsp_cyc     <= cyc_cnt;
    end
  end

  // A cell absent from the presence map reads as fresh.
  assign rsp_rdata   = cell_hit ? raw_data : '0;
  assign rsp_tag     = cell_hit ? raw_tag  : TAG_NONE;
  assign rsp_tag_err = rsp_valid && tag_clash(rsp_tag, instr_tag_q);
endmodule

// File: rtl/tagged_mem_ctl_chk.sv
module tagged_mem_ctl_chk #(
  parameter int DATA_W = 16,
  parameter int CYC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [2:0]        rsp_tag,
  input logic              rsp_tag_err,
  input logic [CYC_W-1:0]  rsp_cyc,
  input logic [CYC_W-1:0]  cyc_cnt,
  input logic              cell_hit
);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R3
  fresh_cell_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cell_hit) |-> (rsp_rdata == '0 && rsp_tag == 3'd0 && !rsp_tag_err));

  // R5
  tag_err_needs_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_tag_err) |-> (rsp_tag != 3'd0));

  // R9
  cyc_stamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (rsp_cyc == $past(cyc_cnt)));

  // R9
  cyc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cyc_cnt == $past(cyc_cnt) + CYC_W'(1)));
endmodule

bind tagged_mem_ctl tagged_mem_ctl_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag), .rsp_tag_err(rsp_tag_err),
  .rsp_cyc(rsp_cyc), .cyc_cnt(cyc_cnt), .cell_hit(cell_hit)
);

// File: tb/tb_tagged_mem_ctl.sv
`timescale 1ns/100ps
module tb_tagged_mem_ctl;
  localparam int NC = 4;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int DEP = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_call = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [2:0] req_tag = '0;
  logic call_start = 1'b0;
  logic [1:0] call_start_ptr = '0;
  logic rsp_valid, rsp_tag_err;
  logic [DW-1:0] rsp_rdata;
  logic [2:0] rsp_tag;
  logic [CW-1:0] rsp_cyc;

  tagged_mem_ctl #(.NUM_CALLS(NC), .ADDR_W(AW), .DATA_W(DW), .CYC_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_call(req_call), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_tag(req_tag), .call_start(call_start), .call_start_ptr(call_start_ptr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_tag(rsp_tag),
    .rsp_tag_err(rsp_tag_err), .rsp_cyc(rsp_cyc)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  int cyc_ref = 0;
  bit done = 1'b0;
  int m_val [NC][DEP];
  int m_tag [NC][DEP];
  bit m_have[NC][DEP];

  always @(posedge clk) cyc_ref <= rst_n ? cyc_ref + 1 : 0;

  function automatic int pat_val(int c, int a, int salt);
    return ((c * 977) + (a * 131) + salt * 29 + 7) & 16'hFFFF;
  endfunction

  function automatic int pat_tag(int c, int a, int salt);
    return 1 + ((c + 3 * a + salt) % 6);
  endfunction

  task automatic chk(string rq, bit ok, string what, int got, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, got, exp);
    end
  endtask

  // One access. The clear is applied to the model before the store (R8).
  task automatic op(string rq, int c, int a, bit wr, int d, int t,
                    bit clr = 1'b0, int cp = 0);
    int ev, et, ec;
    bit ee;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_call = 2'(c); req_addr = AW'(a);
    req_wdata = DW'(d); req_tag = 3'(t);
    call_start = clr; call_start_ptr = 2'(cp);
    ev = m_have[c][a] ? m_val[c][a] : 0;
    et = m_have[c][a] ? m_tag[c][a] : 0;
    ee = (et != 0) && (et != t);
    ec = cyc_ref & 16'hFFFF;
    @(posedge clk); #1;
    call_start = 1'b0;
    if (clr) for (int k = 0; k < DEP; k++) m_have[cp][k] = 1'b0;
    if (wr) begin m_val[c][a] = d; m_tag[c][a] = t; m_have[c][a] = 1'b1; end
    chk(rq, rsp_valid == 1'b1 && rsp_rdata == DW'(ev) && rsp_tag == 3'(et)
            && rsp_tag_err == ee && rsp_cyc == CW'(ec),
        $sformatf("c%0d a%0d wr%0d data/tag/err/cyc", c, a, wr),
        int'(rsp_rdata) * 1000 + int'(rsp_tag) * 10 + int'(rsp_tag_err),
        ev * 1000 + et * 10 + int'(ee));
    if (rsp_cyc != CW'(ec)) chk("R9", 1'b0, "rsp_cyc", int'(rsp_cyc), ec);
  endtask

  task automatic idle_chk(string rq);
    @(negedge clk); req_valid = 1'b0; call_start = 1'b0;
    @(posedge clk); #1;
    chk(rq, rsp_valid == 1'b0, "rsp_valid after idle", int'(rsp_valid), 0);
  endtask

  task automatic sweep_read(string rq, int salt);
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < DEP; a++)
        op(rq, c, a, 1'b0, 0, (c + a + salt) % 7);
  endtask

  initial begin
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < DEP; a++) m_have[c][a] = 1'b0;
    #12;
    // R1: no response while in reset
    chk("R1", rsp_valid == 1'b0, "rsp_valid in reset", int'(rsp_valid), 0);
    @(negedge clk); rst_n = 1'b1;
    idle_chk("R1");
    idle_chk("R2");
    // R3: every cell fresh, any instruction tag
    sweep_read("R3", 0);
    // R6: fill all regions; responses report old (fresh) contents
    for (int c = 0; c < NC; c++)
      for (int a = 0; a < DEP; a++)
        op("R6", c, a, 1'b1, pat_val(c, a, 0), pat_tag(c, a, 0));
    // R4 / R5: read back under several instruction tags
    for (int s = 0; s < 7; s += 2) sweep_read("R5", s);
    // R6: overwrite with new tags; response shows prior contents, tag rule applies
    for (int a = 0; a < DEP; a++) op("R6", 1, a, 1'b1, pat_val(1, a, 5), (a % 7));
    // R4: region 1 changed, regions 0/2/3 untouched
    sweep_read("R4", 3);
    idle_chk("R2");
    // R8: clear region 2 while loading a populated cell of it: pre-clear data
    op("R8", 2, 5, 1'b0, 0, 1, 1'b1, 2);
    // R7: region 2 now fresh, others intact
    sweep_read("R7", 1);
    // R8: clear region 3 while storing into it: the store survives
    op("R8", 3, 9, 1'b1, 16'hBEEF, 4, 1'b1, 3);
    op("R8", 3, 9, 1'b0, 0, 2);
    op("R8", 3, 8, 1'b0, 0, 2);
    // R7: clear with no request, then full sweep
    @(negedge clk); req_valid = 1'b0; call_start = 1'b1; call_start_ptr = 2'd0;
    @(negedge clk); call_start = 1'b0;
    for (int k = 0; k < DEP; k++) m_have[0][k] = 1'b0;
    sweep_read("R7", 4);
    // R3: a cleared region accepts fresh stores and reads them back
    op("R3", 2, 0, 1'b1, 16'h1234, 6);
    op("R4", 2, 0, 1'b0, 0, 6);
    op("R5", 2, 0, 1'b0, 0, 5);
    idle_chk("R2");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule